// File: doc/BRIEF.md
# Translation Cache with Page Permission Checks

This block keeps a small, fully associative set of recent page translations. A lookup presents a 32-bit virtual address and an access kind. The page number is compared against every occupied slot in parallel. On a match, the block joins the cached frame number with the untouched page offset to form the physical address. It then checks the cached permission bits against the access kind. One cycle after the request it reports one of three outcomes: a hit, a miss or a protection fault.

After a miss, an external agent (for example a hardware page-table walker or a trap handler) installs the translation through the refill port. A new page number goes into the slot chosen by a circular victim pointer. A page number that is already cached is rewritten in its own slot. A flush input empties every slot in one cycle, for use when the active page table changes.

The result logic is a four-state machine:
- `ST_IDLE`: no response.
- `ST_HIT`: translation granted.
- `ST_MISS`: no slot matched.
- `ST_FAULT`: a slot matched but the access is refused.

Each cycle the next state is chosen from the current request alone:
- no request gives IDLE;
- a request with no matching slot gives MISS;
- a matching slot that permits the access gives HIT;
- a matching slot that refuses the access gives FAULT.

Every state can reach every other state in one step.

Top module: `tlb_prot`

## Requirements
- R1: After reset no outcome flag is raised, every slot is empty, so any lookup misses, and the victim pointer is at slot 0.
- R2: A lookup accepted on a clock edge raises exactly one of hit, miss and fault during the following cycle. A cycle with no request raises none of them.
- R3: On a hit the physical address is the cached 20-bit frame number in bits 31:12, concatenated with the request's unchanged 12-bit offset in bits 11:0.
- R4: A miss is reported whenever no occupied slot holds the page number. It takes priority over every permission check, including for the reserved access code.
- R5: The access code is 2 bits: 00 read, 01 write, 10 instruction fetch. A read needs the read bit and a write needs the write bit. A refused access reports fault, with the physical address output at zero.
- R6: A fetch needs the execute bit set and the never-execute bit clear. A page with never-execute set still allows data reads when its read bit is set.
- R7: A matching entry whose present bit is clear reports fault for any access kind.
- R8: Access code 11 on a matching entry reports fault.
- R9: A refill with a page number not currently cached writes the slot under the victim pointer. The pointer then advances, wrapping from 15 to 0. With 16 slots, the 17th distinct refill after a flush evicts the first.
- R10: A refill whose page number is already cached overwrites that slot in place and does not advance the victim pointer.
- R11: Flush empties all slots and returns the victim pointer to 0. A refill in the same cycle as a flush is discarded.
- R12: A lookup in the same cycle as a refill sees the slot contents from before that refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 reserved |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | 20 | Page number to install |
| fill_pfn | input | 20 | Frame number to install |
| fill_present | input | 1 | Page is mapped |
| fill_rd | input | 1 | Read allowed |
| fill_wr | input | 1 | Write allowed |
| fill_ex | input | 1 | Execute allowed |
| fill_nx | input | 1 | Never-execute override |
| flush | input | 1 | Empty all slots |
| resp_hit | output | 1 | Translation granted |
| resp_miss | output | 1 | No slot matched |
| resp_fault | output | 1 | Access refused by a matching entry |
| resp_paddr | output | 32 | Physical address, valid on hit; zero on fault |

## Verification
The slot contents are hidden. A wrong occupancy bit, page number or frame number therefore shows up only on the first lookup of the affected page, one cycle after the request, as a hit or miss of the wrong kind or a wrong frame field. A victim-pointer error stays silent until the slot it wrongly picks is looked up again. For that reason the bench fills the whole array and probes both the evicted slot and a surviving one. A bad permission decode appears as a fault in place of a hit, or the reverse, on the very next lookup that uses that access kind.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef struct packed {
        logic present;
        logic rd;
        logic wr;
        logic ex;
        logic nx;
    } perm_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_HIT   = 2'b01,
        ST_MISS  = 2'b10,
        ST_FAULT = 2'b11
    } rsp_state_e;

endpackage

// File: rtl/tlbp_entry_array.sv
module tlbp_entry_array
    import tlbp_pkg::*;
#(
    parameter int N_SLOTS = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = $clog2(N_SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PFN_W-1:0] wr_pfn,
    input  perm_t            wr_perm,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    output perm_t            lk_perm,
    output logic             fl_hit,
    output logic [IDX_W-1:0] fl_idx
);

    logic [N_SLOTS-1:0] occ_q;
    logic [VPN_W-1:0]   vpn_q  [N_SLOTS];
    logic [PFN_W-1:0]   pfn_q  [N_SLOTS];
    perm_t              perm_q [N_SLOTS];

    logic [N_SLOTS-1:0] lk_match;
    logic [N_SLOTS-1:0] fl_match;

    // parallel comparators, one pair per slot
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_cmp
        assign lk_match[g] = occ_q[g] && (vpn_q[g] == lk_vpn);
        assign fl_match[g] = occ_q[g] && (vpn_q[g] == wr_vpn);
    end

    // lowest matching slot wins
    always_comb begin
        lk_hit  = 1'b0;
        lk_pfn  = '0;
        lk_perm = '0;
        fl_hit  = 1'b0;
        fl_idx  = '0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (lk_match[i]) begin
                lk_hit  = 1'b1;
                lk_pfn  = pfn_q[i];
                lk_perm = perm_q[i];
            end
            if (fl_match[i]) begin
                fl_hit = 1'b1;
                fl_idx = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            occ_q <= '0;
        end else if (wr_en) begin
            occ_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clear && !rst) begin
            vpn_q[wr_idx]  <= wr_vpn;
            pfn_q[wr_idx]  <= wr_pfn;
            perm_q[wr_idx] <= wr_perm;
        end
    end

endmodule

// File: rtl/tlbp_rr_ptr.sv
module tlbp_rr_ptr #(
    parameter int N_SLOTS = 16,
    localparam int IDX_W  = $clog2(N_SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);

    logic [IDX_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ptr_q <= '0;
        end else if (advance) begin
            if (ptr_q == IDX_W'(N_SLOTS - 1)) begin
                ptr_q <= '0;
            end else begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/tlbp_perm_check.sv
module tlbp_perm_check
    import tlbp_pkg::*;
(
    input  perm_t perm,
    input  acc_e  acc,
    output logic  allow
);

    always_comb begin
        allow = 1'b0;
        if (perm.present) begin
            unique case (acc)
                ACC_READ:  allow = perm.rd;
                ACC_WRITE: allow = perm.wr;
                ACC_FETCH: allow = perm.ex && !perm.nx;
                ACC_RSVD:  allow = 1'b0;
                default:   allow = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/tlb_prot.sv
module tlb_prot
    import tlbp_pkg::*;
#(
    parameter int N_SLOTS = 16,
    parameter int VA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int PFN_W   = 20,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PA_W   = PFN_W + OFF_W,
    localparam int IDX_W  = $clog2(N_SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_acc,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_present,
    input  logic             fill_rd,
    input  logic             fill_wr,
    input  logic             fill_ex,
    input  logic             fill_nx,
    input  logic             flush,
    output logic             resp_hit,
    output logic             resp_miss,
    output logic             resp_fault,
    output logic [PA_W-1:0]  resp_paddr
);

    rsp_state_e       state_q, state_d;
    logic [PA_W-1:0]  paddr_q;

    logic             lk_hit;
    logic [PFN_W-1:0] lk_pfn;
    perm_t            lk_perm;
    logic             fl_hit;
    logic [IDX_W-1:0] fl_idx;
    logic [IDX_W-1:0] victim;
    logic             allow;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    perm_t            new_perm;

    assign new_perm = '{present: fill_present, rd: fill_rd, wr: fill_wr,
                        ex: fill_ex, nx: fill_nx};
    assign wr_en    = fill_valid && !flush;
    assign wr_idx   = fl_hit ? fl_idx : victim;

    tlbp_entry_array #(
        .N_SLOTS (N_SLOTS),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W)
    ) array_i (
        .clk     (clk),
        .rst     (rst),
        .clear   (flush),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_vpn  (fill_vpn),
        .wr_pfn  (fill_pfn),
        .wr_perm (new_perm),
        .lk_vpn  (req_vaddr[VA_W-1:OFF_W]),
        .lk_hit  (lk_hit),
        .lk_pfn  (lk_pfn),
        .lk_perm (lk_perm),
        .fl_hit  (fl_hit),
        .fl_idx  (fl_idx)
    );

    tlbp_rr_ptr #(
        .N_SLOTS (N_SLOTS)
    ) ptr_i (
        .clk     (clk),
        .rst     (rst),
        .clear   (flush),
        .advance (wr_en && !fl_hit),
        .ptr     (victim)
    );

    tlbp_perm_check perm_i (
        .perm  (lk_perm),
        .acc   (acc_e'(req_acc)),
        .allow (allow)
    );

    // next-state choice
    always_comb begin
        if (!req_valid) begin
            state_d = ST_IDLE;
        end else if (!lk_hit) begin
            state_d = ST_MISS;
        end else if (allow) begin
            state_d = ST_HIT;
        end else begin
            state_d = ST_FAULT;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            paddr_q <= '0;
        end else begin
            state_q <= state_d;
            paddr_q <= (state_d == ST_HIT) ? {lk_pfn, req_vaddr[OFF_W-1:0]} : '0;
        end
    end

    // outputs decoded from state
    always_comb begin
        resp_hit   = 1'b0;
        resp_miss  = 1'b0;
        resp_fault = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_HIT:   resp_hit   = 1'b1;
            ST_MISS:  resp_miss  = 1'b1;
            ST_FAULT: resp_fault = 1'b1;
            default:  ;
        endcase
    end

    assign resp_paddr = paddr_q;

endmodule

// File: rtl/tlb_prot_chk.sv
module tlb_prot_chk #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int PA_W  = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic            flush,
    input logic            resp_hit,
    input logic            resp_miss,
    input logic            resp_fault,
    input logic [PA_W-1:0] resp_paddr
);

    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({resp_hit, resp_miss, resp_fault}));

    // R2
    req_answered_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (resp_hit || resp_miss || resp_fault));

    // R2
    no_req_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !(resp_hit || resp_miss || resp_fault));

    // R3
    offset_kept_chk: assert property (@(posedge clk) disable iff (rst)
        resp_hit |-> resp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));

    // R5
    fault_zero_pa_chk: assert property (@(posedge clk) disable iff (rst)
        resp_fault |-> resp_paddr == '0);

    // R11
    flush_then_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (flush ##1 req_valid) |=> resp_miss);

endmodule

bind tlb_prot tlb_prot_chk #(
    .VA_W  (VA_W),
    .OFF_W (OFF_W),
    .PA_W  (PA_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .flush      (flush),
    .resp_hit   (resp_hit),
    .resp_miss  (resp_miss),
    .resp_fault (resp_fault),
    .resp_paddr (resp_paddr)
);

// File: tb/tlb_prot_tb_top.sv
`timescale 1ns/1ps
module tlb_prot_tb_top;

    localparam int K_NONE  = 0;
    localparam int K_HIT   = 1;
    localparam int K_MISS  = 2;
    localparam int K_FAULT = 3;

    // permission bundles {present, rd, wr, ex, nx}
    localparam logic [4:0] P_ALL   = 5'b11110;
    localparam logic [4:0] P_RO    = 5'b11000;
    localparam logic [4:0] P_WO    = 5'b10100;
    localparam logic [4:0] P_RXNX  = 5'b11011;
    localparam logic [4:0] P_ABSNT = 5'b01110;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic        fill_present = 1'b0;
    logic        fill_rd = 1'b0;
    logic        fill_wr = 1'b0;
    logic        fill_ex = 1'b0;
    logic        fill_nx = 1'b0;
    logic        flush = 1'b0;
    logic        resp_hit, resp_miss, resp_fault;
    logic [31:0] resp_paddr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    tlb_prot dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_present(fill_present), .fill_rd(fill_rd),
        .fill_wr(fill_wr), .fill_ex(fill_ex), .fill_nx(fill_nx),
        .flush(flush), .resp_hit(resp_hit), .resp_miss(resp_miss),
        .resp_fault(resp_fault), .resp_paddr(resp_paddr)
    );

    function automatic int kind_now();
        case ({resp_hit, resp_miss, resp_fault})
            3'b000:  return K_NONE;
            3'b100:  return K_HIT;
            3'b010:  return K_MISS;
            3'b001:  return K_FAULT;
            default: return -1;
        endcase
    endfunction

    task automatic expect_kind(input int exp_k, input logic [31:0] exp_pa,
                               input bit cmp_pa, input string tag);
        int k;
        k = kind_now();
        n_cmp++;
        if (k != exp_k || (cmp_pa && resp_paddr != exp_pa)) begin
            n_bad++;
            $display("FAIL %s: kind=%0d paddr=%h expected kind=%0d paddr=%h",
                     tag, k, resp_paddr, exp_k, exp_pa);
        end
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn,
                        input logic [4:0] p);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn;
        {fill_present, fill_rd, fill_wr, fill_ex, fill_nx} = p;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    // drive one lookup, check the cycle after the sampling edge
    task automatic look(input logic [31:0] va, input logic [1:0] acc,
                        input int exp_k, input logic [31:0] exp_pa,
                        input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
        expect_kind(exp_k, exp_pa, exp_k == K_HIT || exp_k == K_FAULT, tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        expect_kind(K_NONE, '0, 1'b0, "R1 idle after reset");
        look(32'h1234_5678, 2'b00, K_MISS, '0, "R1 empty after reset");
    endtask

    task automatic t_translate();
        fill(20'h12345, 20'hABCDE, P_ALL);
        look(32'h1234_5678, 2'b00, K_HIT, 32'hABCD_E678, "R3 read hit");
        look(32'h1234_5FFF, 2'b01, K_HIT, 32'hABCD_EFFF, "R3 write hit");
        look(32'h1234_5000, 2'b10, K_HIT, 32'hABCD_E000, "R6 fetch hit");
        look(32'h1234_6000, 2'b00, K_MISS, '0, "R4 neighbour page miss");
        @(negedge clk);
        expect_kind(K_NONE, '0, 1'b0, "R2 no request no flag");
    endtask

    task automatic t_perms();
        fill(20'h00100, 20'h00011, P_RO);
        look(32'h0010_0004, 2'b01, K_FAULT, '0, "R5 write to read-only");
        look(32'h0010_0004, 2'b00, K_HIT, 32'h0001_1004, "R5 read of read-only");
        fill(20'h00200, 20'h00022, P_WO);
        look(32'h0020_0008, 2'b00, K_FAULT, '0, "R5 read without rd");
        look(32'h0020_0008, 2'b01, K_HIT, 32'h0002_2008, "R5 write with wr");
        fill(20'h00300, 20'h00033, P_RXNX);
        look(32'h0030_0010, 2'b10, K_FAULT, '0, "R6 fetch from nx page");
        look(32'h0030_0010, 2'b00, K_HIT, 32'h0003_3010, "R6 read of nx page");
        fill(20'h00400, 20'h00044, P_ABSNT);
        look(32'h0040_0000, 2'b00, K_FAULT, '0, "R7 absent read");
        look(32'h0040_0000, 2'b10, K_FAULT, '0, "R7 absent fetch");
        look(32'h1234_5678, 2'b11, K_FAULT, '0, "R8 reserved code");
        look(32'h0077_7000, 2'b11, K_MISS, '0, "R4 miss beats reserved");
    endtask

    task automatic t_flush();
        @(negedge clk);
        flush = 1'b1; fill_valid = 1'b1; fill_vpn = 20'h00500;
        fill_pfn = 20'h00055;
        {fill_present, fill_rd, fill_wr, fill_ex, fill_nx} = P_ALL;
        @(negedge clk);
        flush = 1'b0; fill_valid = 1'b0;
        look(32'h1234_5678, 2'b00, K_MISS, '0, "R11 flushed entry");
        look(32'h0050_0000, 2'b00, K_MISS, '0, "R11 fill dropped by flush");
    endtask

    task automatic t_round_robin();
        do_flush();
        for (int i = 0; i < 16; i++) fill(20'h01000 + 20'(i), 20'h0A000 + 20'(i), P_ALL);
        look(32'h0100_0000, 2'b00, K_HIT, 32'h0A00_0000, "R9 first of 16 kept");
        look(32'h0100_F000, 2'b00, K_HIT, 32'h0A00_F000, "R9 last of 16 kept");
        fill(20'h01010, 20'h0A010, P_ALL);
        look(32'h0100_0000, 2'b00, K_MISS, '0, "R9 17th evicts first");
        look(32'h0100_1000, 2'b00, K_HIT, 32'h0A00_1000, "R9 second survives");
        look(32'h0101_0000, 2'b00, K_HIT, 32'h0A01_0000, "R9 17th installed");
    endtask

    task automatic t_update();
        do_flush();
        fill(20'h02000, 20'h00001, P_ALL);
        fill(20'h02001, 20'h00002, P_ALL);
        fill(20'h02000, 20'h00077, P_ALL);
        look(32'h0200_0123, 2'b00, K_HIT, 32'h0007_7123, "R10 rewritten in place");
        for (int i = 0; i < 14; i++) fill(20'h03000 + 20'(i), 20'h0B000 + 20'(i), P_ALL);
        look(32'h0200_0123, 2'b00, K_HIT, 32'h0007_7123, "R10 pointer not advanced");
        fill(20'h04000, 20'h0C000, P_ALL);
        look(32'h0200_0123, 2'b00, K_MISS, '0, "R10 slot 0 reused after wrap");
        look(32'h0200_1000, 2'b00, K_HIT, 32'h0000_2000, "R9 slot 1 survives");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = 20'h05000; fill_pfn = 20'h0D000;
        {fill_present, fill_rd, fill_wr, fill_ex, fill_nx} = P_ALL;
        req_valid = 1'b1; req_vaddr = 32'h0500_0abc; req_acc = 2'b00;
        @(negedge clk);
        fill_valid = 1'b0; req_valid = 1'b0;
        expect_kind(K_MISS, '0, 1'b0, "R12 lookup sees old contents");
        look(32'h0500_0abc, 2'b00, K_HIT, 32'h0D00_0ABC, "R12 visible next cycle");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_translate();
        t_perms();
        t_flush();
        t_round_robin();
        t_update();
        t_same_cycle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule